// File: doc/BRIEF.md
# Dual-Bank Filter Kernel Register File

This block is the host-facing register file of a nine-tap image filter. A host writes it with a 3-bit address, a byte of data and a load strobe. One address holds a small configuration byte. Two addresses each fill one of two nine-entry coefficient banks. Two more addresses choose which bank feeds the multipliers. The multiply-accumulate datapath sits outside this block and reads the active bank and the decoded configuration fields straight from the output pins.

Each bank is filled through a single address. Successive strobes to that address store taps A, B, C and so on through I, in that order. An internal per-bank pointer tracks the next tap. The host can refill the idle bank while the datapath keeps running on the other one. It then flips the selection with one more write, and the new kernel is live from the clock edge that captured that write. No processing cycle is lost.

The load strobe is sampled on the clock. Each low-to-high transition of the sampled strobe is one write, and it takes the address and data present in that same cycle. The host pins are a plain register-write port with no back-pressure. The outputs are held levels and have no handshake.

Top module: `kernel_coef_regs`

## Requirements
- R1: After reset, every tap of both banks is zero, the configuration fields are zero, and bank 0 is active (`active_bank_o` = 0).
- R2: A write happens only on a clock edge where `ld_i` is high and was low at the previous edge. Holding `ld_i` high for several cycles performs exactly one write, using the data present at the first of those edges.
- R3: A write to address 3'b010 stores `din_i` into bank 0 at its load pointer. Taps are filled in the order A to I. The output bus `coef_o` carries tap A in bits [7:0], B in [15:8], and so on up to I in [71:64].
- R4: A write to address 3'b011 loads bank 1 in the same way and does not touch bank 0.
- R5: After tap I of a bank has been written, that bank's pointer returns to A, so a tenth consecutive write overwrites tap A.
- R6: Any write to an address other than a bank's own load address (the other bank, the configuration, a select, a reserved or the no-op code) returns that bank's pointer to A.
- R7: A write to address 3'b100 sets the configuration. Bit 0 drives `fmt_signed_o`, bit 1 drives `mode_2d_o`, and bits 3:2 drive `round_o`. Bits 7:4 are ignored.
- R8: A write to 3'b101 makes bank 0 active and a write to 3'b110 makes bank 1 active. `coef_o` and `active_bank_o` show the new bank right after the clock edge that captured the write.
- R9: Writes to 3'b000, 3'b001 and 3'b111 leave both banks, the configuration fields and the bank selection unchanged.
- R10: Loading the inactive bank leaves `coef_o` unchanged until that bank is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous global reset |
| ld_i | input | 1 | Load strobe, sampled on the clock; a rising transition is one write |
| addr_i | input | 3 | Write target code |
| din_i | input | 8 | Write data byte |
| coef_o | output | 72 | Nine taps of the active bank, tap A in the low byte |
| active_bank_o | output | 1 | Index of the bank currently driving `coef_o` |
| fmt_signed_o | output | 1 | Operand format: 1 means two's complement, 0 means unsigned |
| mode_2d_o | output | 1 | Filter mode: 1 means 3x3 two-dimensional, 0 means nine-tap one-dimensional |
| round_o | output | 2 | Output rounding code |

## Verification
The bench builds the block with its default 8-bit data width and nine taps. With these values every one of the 256 configuration bytes can be written and its decoded fields compared, and a full pass through a bank plus the wrap back onto tap A fits in a few writes. The bench keeps its own model of both banks, their pointers and the selection. It compares the whole 72-bit tap bus after every write, including writes to reserved codes, held strobes, interrupted partial loads and bank switches checked in the cycle right after the capturing edge.

// File: rtl/kcr_pkg.sv
package kcr_pkg;

  typedef enum logic [2:0] {
    OP_RSV0    = 3'd0,
    OP_RSV1    = 3'd1,
    OP_LOAD_B0 = 3'd2,
    OP_LOAD_B1 = 3'd3,
    OP_CFG     = 3'd4,
    OP_SEL_B0  = 3'd5,
    OP_SEL_B1  = 3'd6,
    OP_NOP     = 3'd7
  } op_e;

  localparam int NBANKS = 2;
  localparam int CFG_W  = 4;

  typedef struct packed {
    logic [1:0] rnd;
    logic       mode_2d;
    logic       fmt_signed;
  } cfg_t;

endpackage

// File: rtl/kcr_strobe_edge.sv
module kcr_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_i,
  output logic wr_o
);

  logic ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_q <= 1'b1;
    else        ld_q <= ld_i;
  end

  assign wr_o = ld_i & ~ld_q;

  AST_ONE_WRITE_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> !wr_o); // R2

endmodule

// File: rtl/kcr_addr_decode.sv
module kcr_addr_decode
  import kcr_pkg::*;
(
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  output logic [NBANKS-1:0] bank_wr_o,
  output logic              cfg_wr_o,
  output logic              sel_wr_o,
  output logic              sel_bank_o
);

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank_dec
    localparam logic [2:0] LOAD_CODE = 3'(int'(OP_LOAD_B0) + b);
    assign bank_wr_o[b] = wr_i && (addr_i == LOAD_CODE);
  end

  always_comb begin
    cfg_wr_o   = 1'b0;
    sel_wr_o   = 1'b0;
    sel_bank_o = 1'b0;
    if (wr_i) begin
      case (op_e'(addr_i))
        OP_CFG:    cfg_wr_o = 1'b1;
        OP_SEL_B0: sel_wr_o = 1'b1;
        OP_SEL_B1: begin
          sel_wr_o   = 1'b1;
          sel_bank_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/kcr_coef_bank.sv
module kcr_coef_bank #(
  parameter int DATA_W = 8,
  parameter int NTAPS  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic                    rewind_i,
  input  logic [DATA_W-1:0]       din_i,
  output logic [NTAPS*DATA_W-1:0] taps_o
);

  localparam int PTR_W = $clog2(NTAPS + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NTAPS - 1);

  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] tap_q [NTAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ptr_q <= '0;
    else if (wr_i)           ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    else if (rewind_i)       ptr_q <= '0;
  end

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    localparam logic [PTR_W-1:0] IDX = PTR_W'(t);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     tap_q[t] <= '0;
      else if (wr_i && ptr_q == IDX)  tap_q[t] <= din_i;
    end
    assign taps_o[t*DATA_W +: DATA_W] = tap_q[t];
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST); // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ptr_q == LAST) |=> ptr_q == '0); // R5
  AST_PTR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind_i && !wr_i) |=> ptr_q == '0); // R6
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(taps_o)); // R9

endmodule

// File: rtl/kernel_coef_regs.sv
module kernel_coef_regs
  import kcr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NTAPS  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_i,
  input  logic [2:0]              addr_i,
  input  logic [DATA_W-1:0]       din_i,
  output logic [NTAPS*DATA_W-1:0] coef_o,
  output logic                    active_bank_o,
  output logic                    fmt_signed_o,
  output logic                    mode_2d_o,
  output logic [1:0]              round_o
);

  localparam int FLAT_W = NTAPS * DATA_W;

  logic              wr_pulse;
  logic [NBANKS-1:0] bank_wr;
  logic              cfg_wr;
  logic              sel_wr;
  logic              sel_bank;
  logic              sel_q;
  cfg_t              cfg_q;
  logic [FLAT_W-1:0] bank_taps [NBANKS];

  kcr_strobe_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (ld_i),
    .wr_o  (wr_pulse)
  );

  kcr_addr_decode u_dec (
    .wr_i       (wr_pulse),
    .addr_i     (addr_i),
    .bank_wr_o  (bank_wr),
    .cfg_wr_o   (cfg_wr),
    .sel_wr_o   (sel_wr),
    .sel_bank_o (sel_bank)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    kcr_coef_bank #(.DATA_W(DATA_W), .NTAPS(NTAPS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (bank_wr[b]),
      .rewind_i (wr_pulse & ~bank_wr[b]),
      .din_i    (din_i),
      .taps_o   (bank_taps[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_t'(din_i[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (sel_wr) sel_q <= sel_bank;
  end

  assign coef_o        = bank_taps[sel_q];
  assign active_bank_o = sel_q;
  assign fmt_signed_o  = cfg_q.fmt_signed;
  assign mode_2d_o     = cfg_q.mode_2d;
  assign round_o       = cfg_q.rnd;

  AST_DECODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bank_wr, cfg_wr, sel_wr})); // R9
  AST_SELECT_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !sel_bank) |=> !active_bank_o); // R8
  AST_SELECT_BANK1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && sel_bank) |=> active_bank_o); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable({fmt_signed_o, mode_2d_o, round_o})); // R9
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(active_bank_o)); // R9

endmodule

// File: tb/kernel_coef_regs_test.sv
module kernel_coef_regs_test;

  localparam int DW = 8;
  localparam int NT = 9;
  localparam int FW = DW * NT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_i = 1'b0;
  logic [2:0]    addr_i = 3'd7;
  logic [DW-1:0] din_i = '0;
  logic [FW-1:0] coef_o;
  logic          active_bank_o, fmt_signed_o, mode_2d_o;
  logic [1:0]    round_o;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] m_bank [2][NT];
  int            m_ptr [2];
  logic [3:0]    m_cfg;
  logic          m_sel;

  always #10 clk = ~clk;

  kernel_coef_regs #(.DATA_W(DW), .NTAPS(NT)) uut (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .addr_i(addr_i), .din_i(din_i),
    .coef_o(coef_o), .active_bank_o(active_bank_o), .fmt_signed_o(fmt_signed_o),
    .mode_2d_o(mode_2d_o), .round_o(round_o)
  );

  function automatic logic [FW-1:0] pack_bank(input int b);
    logic [FW-1:0] v;
    for (int t = 0; t < NT; t++) v[t*DW +: DW] = m_bank[b][t];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act,
                     input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [FW-1:0] e;
    e = pack_bank(int'(m_sel));
    chk(coef_o === e, req, coef_o, e);
    chk(active_bank_o === m_sel, req, FW'(active_bank_o), FW'(m_sel));
    chk({round_o, mode_2d_o, fmt_signed_o} === m_cfg, req,
        FW'({round_o, mode_2d_o, fmt_signed_o}), FW'(m_cfg));
  endtask

  task automatic model_write(input logic [2:0] a, input logic [DW-1:0] d);
    if (a == 3'd2 || a == 3'd3) begin
      int b = int'(a) - 2;
      m_bank[b][m_ptr[b]] = d;
      m_ptr[b] = (m_ptr[b] == NT - 1) ? 0 : m_ptr[b] + 1;
      m_ptr[1 - b] = 0;
    end else begin
      m_ptr[0] = 0;
      m_ptr[1] = 0;
      if (a == 3'd4) m_cfg = d[3:0];
      if (a == 3'd5) m_sel = 1'b0;
      if (a == 3'd6) m_sel = 1'b1;
    end
  endtask

  // Drive one strobe; returns just after the capturing edge.
  task automatic do_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr_i = a; din_i = d; ld_i = 1'b1;
    @(negedge clk);
    ld_i = 1'b0;
    model_write(a, d);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int t = 0; t < NT; t++) m_bank[b][t] = '0;
      m_ptr[b] = 0;
    end
    m_cfg = '0;
    m_sel = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // R3: fill bank 0, check after every write
    for (int t = 0; t < NT; t++) begin
      do_wr(3'd2, DW'(t * 17 + 3));
      check_all("R3 bank0 sequential load");
    end

    // R4 / R10: fill bank 1 while bank 0 stays active
    for (int t = 0; t < NT; t++) begin
      do_wr(3'd3, DW'(8'h80 + t * 29));
      check_all("R10 inactive bank load leaves output");
    end

    // R8: switch, checked right after the capturing edge
    do_wr(3'd6, 8'h00);
    check_all("R8 select bank1");
    chk(coef_o === pack_bank(1), "R4 bank1 contents", coef_o, pack_bank(1));
    do_wr(3'd5, 8'h00);
    check_all("R8 select bank0");
    do_wr(3'd6, 8'hFF);
    check_all("R8 reselect bank1");

    // R5: ten writes to bank 0, tenth lands on tap A
    for (int t = 0; t < NT + 1; t++) do_wr(3'd2, DW'(8'hC0 + t));
    do_wr(3'd5, 8'h00);
    check_all("R5 pointer wrap");
    chk(coef_o[DW-1:0] === DW'(8'hC0 + NT), "R5 tap A overwritten",
        FW'(coef_o[DW-1:0]), FW'(8'hC0 + NT));

    // R6: partial load interrupted by each other kind of address
    for (int k = 0; k < 6; k++) begin
      logic [2:0] other;
      other = (k == 0) ? 3'd7 : (k == 1) ? 3'd0 : (k == 2) ? 3'd1 :
              (k == 3) ? 3'd3 : (k == 4) ? 3'd4 : 3'd5;
      for (int t = 0; t < 4; t++) do_wr(3'd2, DW'(8'h10 * k + t));
      do_wr(other, DW'(8'h05 + k));
      do_wr(3'd2, DW'(8'hA0 + k));
      do_wr(3'd5, 8'h00);
      check_all("R6 pointer rewind");
    end

    // R7: exhaustive configuration byte sweep
    for (int v = 0; v < 256; v++) begin
      do_wr(3'd4, DW'(v));
      check_all("R7 config decode");
    end

    // R9: reserved and no-op codes change nothing
    do_wr(3'd6, 8'h00);
    do_wr(3'd4, 8'h0B);
    for (int k = 0; k < 3; k++) begin
      logic [2:0] a;
      a = (k == 0) ? 3'd0 : (k == 1) ? 3'd1 : 3'd7;
      for (int v = 0; v < 4; v++) begin
        do_wr(a, DW'(8'h3C * v + k));
        check_all("R9 reserved or no-op write");
      end
    end

    // R2: strobe held high with changing data writes once
    do_wr(3'd4, 8'h00);
    @(negedge clk);
    addr_i = 3'd4; din_i = 8'h06; ld_i = 1'b1;
    model_write(3'd4, 8'h06);
    @(negedge clk);
    din_i = 8'h09;
    @(negedge clk);
    din_i = 8'h0F;
    @(negedge clk);
    check_all("R2 held strobe single write");
    ld_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    addr_i = 3'd3; din_i = 8'h77; ld_i = 1'b1;
    model_write(3'd3, 8'h77);
    @(negedge clk);
    din_i = 8'h78;
    @(negedge clk);
    ld_i = 1'b0;
    @(negedge clk);
    check_all("R2 held strobe bank write once");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule